// File: doc/BRIEF.md
# DDR Burst Column Address Sequencer

This block produces the column addresses for one read or write burst of a double-data-rate SDRAM controller. A mode-load strobe delivers a 16-bit mode word. From it the block keeps a burst length of 2, 4 or 8 beats and a burst order, either sequential or interleaved. The same setting serves reads and writes alike.

A command strobe carries a starting column. From the next cycle on the block presents one column address per clock. A valid flag marks each beat and a last flag marks the final beat. Every beat stays inside the aligned group of columns whose size equals the burst length. In sequential order the low bits count upward modulo the length. In interleaved order they are the starting offset XOR the beat index. The bits above the group never change during a burst.

A new command on the final beat follows on with no idle cycle. A new command earlier in a burst cuts that burst short and restarts from the new column. Command scheduling, data capture and read latency belong to other blocks.

Top module: `ddr_burst_colseq`

## Requirements
- R1: A mode word with bits 15:14 equal to 00 and a valid length code is stored. Bits 2:0 set the length: 001 gives 2, 010 gives 4, 011 gives 8. Bit 3 sets the order: 0 sequential, 1 interleaved.
- R2: After reset the length is 2 and the order is sequential, and `col_vld_o`, `col_last_o` and `mode_err_o` are low.
- R3: A mode word with bits 15:14 = 00 and any other length code (000, 1xx) leaves both length and order unchanged. `mode_err_o` is then high for exactly the one cycle after the load edge.
- R4: A mode word with bits 15:14 other than 00 changes nothing and does not raise `mode_err_o`.
- R5: A command sampled at a clock edge puts the start column on `col_o` with `col_vld_o` high after that edge. A burst without interruption then gives exactly L beats on consecutive cycles, where L is the burst length.
- R6: In sequential order, beat n carries the low log2(L) bits (start + n) mod L. The bits above them equal those of the start column.
- R7: In interleaved order, beat n carries the low log2(L) bits start XOR n. The bits above them equal those of the start column.
- R8: `col_last_o` is high on the final beat only. `col_vld_o` falls after the final beat unless a command was sampled on that beat.
- R9: A command sampled on the final beat starts the next burst in the following cycle with no gap in `col_vld_o`.
- R10: A command sampled before the final beat ends the current burst at once. The new burst begins from the new start column in the next cycle.
- R11: A burst keeps the length and order that were in force when its command was sampled. A mode load during the burst does not alter it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_ld_i | input | 1 | Mode word load strobe |
| mode_word_i | input | 16 | Mode word (bank bits 15:14, order bit 3, length code 2:0) |
| cmd_i | input | 1 | Read/write command strobe |
| start_col_i | input | COL_W | Starting column of the burst |
| col_o | output | COL_W | Column address of the current beat |
| col_vld_o | output | 1 | Beat valid |
| col_last_o | output | 1 | Final beat of the burst |
| mode_err_o | output | 1 | One-cycle pulse after a rejected length code |

## Verification
The bench builds the block with the default column width of 10 bits. With this width, start columns near the top of the range, such as 0x3FE with length 8, can wrap inside the highest group while the upper bits stay fixed. All six combinations of length and order are covered, so the group mask is exercised at each of its widths in both orders. Back-to-back and truncating commands are issued at exact beat positions, so any gap in the beat stream or any extra beat shows up against the expected queue.

// File: rtl/ddr_burst_pkg.sv
package ddr_burst_pkg;
  localparam int BEAT_W = 3;  // log2 of the longest burst

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } burst_ord_e;

  typedef logic [1:0] bl_log2_t;

  function automatic logic bl_code_ok(input logic [2:0] code);
    return (code[2] == 1'b0) && (code[1:0] != 2'b00);
  endfunction

  function automatic logic [BEAT_W-1:0] bl_mask(input bl_log2_t bl);
    return ~({BEAT_W{1'b1}} << bl);
  endfunction
endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
  import ddr_burst_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ld_i,
  input  logic [15:0] word_i,
  output bl_log2_t    bl_o,
  output burst_ord_e  ord_o,
  output logic        err_o
);
  logic       base_sel;
  logic [2:0] code;

  assign base_sel = (word_i[15:14] == 2'b00);
  assign code     = word_i[2:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bl_o  <= 2'd1;
      ord_o <= ORD_SEQ;
      err_o <= 1'b0;
    end else begin
      err_o <= 1'b0;
      if (ld_i && base_sel) begin
        if (bl_code_ok(code)) begin
          bl_o  <= code[1:0];
          ord_o <= burst_ord_e'(word_i[3]);
        end else begin
          err_o <= 1'b1;
        end
      end
    end
  end

  assert_reserved_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && base_sel && !bl_code_ok(code)) |=> (err_o && $stable(bl_o) && $stable(ord_o)));

  assert_bank_ignored_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && !base_sel) |=> (!err_o && $stable(bl_o) && $stable(ord_o)));

  assert_err_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> !err_o);
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import ddr_burst_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  bl_log2_t          bl_i,
  input  burst_ord_e        ord_i,
  output logic              act_o,
  output logic              last_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic [COL_W-1:0]  base_o,
  output bl_log2_t          bl_o,
  output burst_ord_e        ord_o
);
  logic [BEAT_W-1:0] end_beat;

  assign end_beat = bl_mask(bl_o);
  assign last_o   = act_o && (beat_o == end_beat);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o  <= 1'b0;
      beat_o <= '0;
      base_o <= '0;
      bl_o   <= 2'd1;
      ord_o  <= ORD_SEQ;
    end else if (cmd_i) begin
      act_o  <= 1'b1;
      beat_o <= '0;
      base_o <= start_col_i;
      bl_o   <= bl_i;
      ord_o  <= ord_i;
    end else if (act_o) begin
      if (last_o) act_o <= 1'b0;
      else        beat_o <= beat_o + 1'b1;
    end
  end

  assert_cmd_starts_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i |=> (act_o && beat_o == '0));

  assert_stop_after_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !cmd_i) |=> !act_o);

  assert_setting_held_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o && !cmd_i) |=> ($stable(bl_o) && $stable(ord_o) && $stable(base_o)));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import ddr_burst_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0]  base_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  bl_log2_t          bl_i,
  input  burst_ord_e        ord_i,
  output logic [COL_W-1:0]  col_o
);
  logic [BEAT_W-1:0] mask, lo_start, lo_step, lo_out;

  always_comb begin
    mask     = bl_mask(bl_i);
    lo_start = base_i[BEAT_W-1:0];
    lo_step  = (ord_i == ORD_ILV) ? (lo_start ^ beat_i) : (lo_start + beat_i);
    lo_out   = (lo_start & ~mask) | (lo_step & mask);
  end

  generate
    if (COL_W > BEAT_W) begin : g_hi
      assign col_o = {base_i[COL_W-1:BEAT_W], lo_out};
    end else begin : g_narrow
      assign col_o = lo_out[COL_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/ddr_burst_colseq.sv
module ddr_burst_colseq
  import ddr_burst_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_ld_i,
  input  logic [15:0]      mode_word_i,
  input  logic             cmd_i,
  input  logic [COL_W-1:0] start_col_i,
  output logic [COL_W-1:0] col_o,
  output logic             col_vld_o,
  output logic             col_last_o,
  output logic             mode_err_o
);
  bl_log2_t          mode_bl, burst_bl;
  burst_ord_e        mode_ord, burst_ord;
  logic [BEAT_W-1:0] beat;
  logic [COL_W-1:0]  base;
  logic [BEAT_W-1:0] cur_mask;

  burst_mode_reg u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (mode_ld_i),
    .word_i (mode_word_i),
    .bl_o   (mode_bl),
    .ord_o  (mode_ord),
    .err_o  (mode_err_o)
  );

  burst_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd_i),
    .start_col_i (start_col_i),
    .bl_i        (mode_bl),
    .ord_i       (mode_ord),
    .act_o       (col_vld_o),
    .last_o      (col_last_o),
    .beat_o      (beat),
    .base_o      (base),
    .bl_o        (burst_bl),
    .ord_o       (burst_ord)
  );

  burst_addr_gen #(.COL_W(COL_W)) u_addr (
    .base_i (base),
    .beat_i (beat),
    .bl_i   (burst_bl),
    .ord_i  (burst_ord),
    .col_o  (col_o)
  );

  assign cur_mask = bl_mask(burst_bl);

  assert_first_beat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i |=> (col_o == $past(start_col_i)));

  assert_upper_fixed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_vld_o && !col_last_o && !cmd_i) |=>
      ((col_o & ~COL_W'(cur_mask)) == ($past(col_o) & ~COL_W'(cur_mask))));

  assert_seq_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_vld_o && !col_last_o && !cmd_i && burst_ord == ORD_SEQ) |=>
      ((col_o[BEAT_W-1:0] & cur_mask) == (($past(col_o[BEAT_W-1:0]) + 1'b1) & cur_mask)));

  assert_last_only_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_last_o |-> col_vld_o);
endmodule

// File: tb/ddr_burst_colseq_tb_top.sv
module ddr_burst_colseq_tb_top;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mode_ld = 1'b0;
  logic [15:0]      mode_word = '0;
  logic             cmd = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [COL_W-1:0] col;
  logic             col_vld, col_last, mode_err;

  always #4 clk = ~clk;

  ddr_burst_colseq #(.COL_W(COL_W)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mode_ld_i   (mode_ld),
    .mode_word_i (mode_word),
    .cmd_i       (cmd),
    .start_col_i (start_col),
    .col_o       (col),
    .col_vld_o   (col_vld),
    .col_last_o  (col_last),
    .mode_err_o  (mode_err)
  );

  typedef struct {
    logic [COL_W-1:0] col;
    logic             last;
    string            req;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   m_len = 2;
  bit   m_ilv = 1'b0;
  bit   mon_on = 1'b0;
  int   cyc = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Monitor: compare each beat against the scoreboard queue
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      if (col_vld) begin
        if (exp_q.size() == 0) begin
          chk("R8 beat beyond burst", 32'(col_vld), 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(e.req, 32'(col), 32'(e.col));
          chk("R8", 32'(col_last), 32'(e.last));
        end
      end else if (exp_q.size() != 0) begin
        chk("R5 missing beat", 32'(col_vld), 32'd1);
        exp_q.delete();
      end
    end
  end

  task automatic issue(input logic [COL_W-1:0] st, input string req);
    int lo, hi;
    @(posedge clk); #1;
    cmd = 1'b1;
    start_col = st;
    @(negedge clk); #1;
    exp_q.delete();
    lo = int'(st) % m_len;
    hi = int'(st) - lo;
    for (int n = 0; n < m_len; n++) begin
      exp_t e;
      e.col  = COL_W'(hi + (m_ilv ? (lo ^ n) : ((lo + n) % m_len)));
      e.last = (n == m_len - 1);
      e.req  = req;
      exp_q.push_back(e);
    end
    @(posedge clk); #1;
    cmd = 1'b0;
  endtask

  task automatic load(input logic [15:0] w, input logic exp_err, input string req);
    @(posedge clk); #1;
    mode_ld = 1'b1;
    mode_word = w;
    @(posedge clk); #1;
    mode_ld = 1'b0;
    chk(req, 32'(mode_err), 32'(exp_err));
    if (w[15:14] == 2'b00 && !w[2] && w[1:0] != 2'b00) begin
      m_len = 1 << w[1:0];
      m_ilv = w[3];
    end
    @(posedge clk); #1;
    chk(req, 32'(mode_err), 32'd0);
  endtask

  task automatic drain(input string req);
    repeat (12) @(posedge clk);
    #1;
    chk(req, 32'(exp_q.size()), 32'd0);
    chk(req, 32'(col_vld), 32'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2", 32'(col_vld), 32'd0);
    chk("R2", 32'(col_last), 32'd0);
    chk("R2", 32'(mode_err), 32'd0);
    rst_n = 1'b1;
    mon_on = 1'b1;

    issue(10'h005, "R2");
    drain("R5");

    load(16'h0002, 1'b0, "R1");
    issue(10'h01E, "R6");
    drain("R5");
    load(16'h000B, 1'b0, "R1");
    issue(10'h0A3, "R7");
    drain("R5");
    load(16'h0003, 1'b0, "R1");
    issue(10'h3FE, "R6");
    drain("R5");
    load(16'h0009, 1'b0, "R1");
    issue(10'h2B1, "R7");
    drain("R5");
    load(16'h000A, 1'b0, "R1");
    issue(10'h10E, "R7");
    drain("R5");

    load(16'h000C, 1'b1, "R3");
    load(16'h0008, 1'b1, "R3");
    load(16'h0005, 1'b1, "R3");
    issue(10'h045, "R3");
    drain("R3");

    load(16'hC003, 1'b0, "R4");
    load(16'h4001, 1'b0, "R4");
    load(16'h8000, 1'b0, "R4");
    issue(10'h033, "R4");
    drain("R4");

    load(16'h0001, 1'b0, "R1");
    issue(10'h100, "R9");
    issue(10'h203, "R9");
    issue(10'h0FF, "R9");
    drain("R9");
    load(16'h0002, 1'b0, "R1");
    issue(10'h1A5, "R9");
    repeat (2) @(posedge clk);
    issue(10'h2C2, "R9");
    drain("R9");

    load(16'h0003, 1'b0, "R1");
    issue(10'h050, "R10");
    repeat (1) @(posedge clk);
    issue(10'h1C4, "R10");
    drain("R10");
    load(16'h000B, 1'b0, "R1");
    issue(10'h0F1, "R10");
    issue(10'h3A6, "R10");
    drain("R10");

    load(16'h0003, 1'b0, "R1");
    issue(10'h077, "R11");
    mode_ld = 1'b0;
    @(posedge clk); #1;
    mode_ld = 1'b1;
    mode_word = 16'h0009;
    @(posedge clk); #1;
    mode_ld = 1'b0;
    drain("R11");
    m_len = 2;
    m_ilv = 1'b1;
    issue(10'h077, "R11");
    drain("R11");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule